// File: doc/BRIEF.md
# DRAM Traffic Profiling Counter Bank

This block sits next to a DRAM controller and keeps six running statistics about its traffic: elapsed cycles, busy cycles, completed reads, completed writes, bytes read and bytes written. The controller drives per-cycle strobes into the block. A busy strobe is one of them. A read-completion strobe and a write-completion strobe each come with a byte-count field.

Software reaches the bank through a plain 32-bit register port. One control register turns counting on or off and pauses it. The same register clears the counters and reports a sticky overflow flag for the cycle counter. A typical session has four steps:

- Clear the bank and the flag with one write.
- Enable counting.
- Pause the bank while the counters are read as one coherent snapshot.
- Resume counting from the held values.

Top module: `mem_prof_counters`

## Requirements
- R1: After reset all six counters read 0, and the control register reads 0.
- R2: The control register is at offset 0x410.
  - Bit 0 (enable) and bit 2 (freeze) read back as last written.
  - Bit 1 (clear) always reads 0.
  - Bit 3 reads the overflow flag.
  - All other bits read 0.
- R3: A control write with bit 1 set makes all six counters 0 on the next cycle.
  - If bit 3 is also set in that write, the overflow flag is cleared too.
  - With bit 1 alone, the flag keeps its value.
- R4: Counting happens only when enable is 1 and freeze is 0, as held before the clock edge. Otherwise no counter changes, whatever the event inputs do.
- R5: While counting, the total-cycle counter adds 1 every cycle. The busy counter adds 1 on each cycle whose busy strobe is high.
- R6: While counting, the read-access and write-access counters add 1 for each cycle with their completion strobe.
  - The read-byte and write-byte counters add that cycle's byte field.
  - A byte field without its strobe is ignored.
- R7: The counters are read at word offsets 0x418, 0x41C, 0x420, 0x424, 0x428 and 0x42C. In that order they are: total cycles, busy cycles, read accesses, write accesses, read bytes, write bytes. Each value is zero-extended to 32 bits.
- R8: When the total-cycle counter wraps from all ones to zero, the overflow flag is set. It stays set until a write with bits 1 and 3 both set.
- R9: A read of any other offset returns 0. Writes to the counter offsets, or to any offset other than 0x410, change nothing.
- R10: Every counter wraps modulo 2^CNT_W.
- R11: After a freeze, a write of enable alone resumes counting from the held values, with nothing lost or cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register byte offset for reads and writes |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| ev_busy | input | 1 | Controller busy this cycle |
| ev_rd_done | input | 1 | A read transfer completed this cycle |
| ev_rd_bytes | input | BYTE_W | Bytes in the completed read |
| ev_wr_done | input | 1 | A write transfer completed this cycle |
| ev_wr_bytes | input | BYTE_W | Bytes in the completed write |

## Verification
The assertions check the following on every cycle:
- A clear leaves each counter at zero.
- An idle counter holds its value.
- The cycle counter steps by exactly one whenever counting is active.
- The overflow flag is sticky and is set on a wrap.
- Enable and freeze take the written values.

Only the bench scenarios can show the remaining behaviour:
- The byte counters accumulate the byte field and ignore it without a strobe.
- The counters sit at the right offsets in the right order.
- Unmapped reads return zero and stray writes are ignored.
- Resume after freeze continues from the held values.
- Clear without bit 3 keeps the flag.

The bench shows these by comparing each register against an arithmetic model over an exhaustive sweep of the event inputs.

// File: rtl/prof_pkg.sv
package prof_pkg;

   localparam int NUM_CNT = 6;
   localparam int DATA_W  = 32;

   // counter slots, in register order
   typedef enum logic [2:0] {
      CNT_TOTAL  = 3'd0,
      CNT_BUSY   = 3'd1,
      CNT_RDACC  = 3'd2,
      CNT_WRACC  = 3'd3,
      CNT_RDBYTE = 3'd4,
      CNT_WRBYTE = 3'd5
   } cnt_slot_e;

   // control register bit positions
   localparam int CB_EN  = 0;
   localparam int CB_CLR = 1;
   localparam int CB_FRZ = 2;
   localparam int CB_OVF = 3;
   localparam int CB_W   = 4;

endpackage

// File: rtl/prof_counter.sv
module prof_counter #(
   parameter int CNT_W = 32,
   parameter int INC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc_en,
   input  logic [INC_W-1:0] inc_val,
   output logic [CNT_W-1:0] count
);

   if (INC_W < 1 || INC_W > CNT_W) begin : g_bad_inc
      $error("prof_counter: INC_W must be in 1..CNT_W");
   end

   logic [CNT_W-1:0] sum;

   assign sum = count + CNT_W'(inc_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (clr)    count <= '0;
      else if (inc_en) count <= sum;
   end

   assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (count == '0));

   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc_en) |=> $stable(count));

endmodule

// File: rtl/prof_ctrl.sv
module prof_ctrl
   import prof_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int CTRL_OFS = 'h410
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [CB_W-1:0]   ctrl_wdata,
   input  logic              tot_wrap,
   output logic              count_en,
   output logic              cnt_clr,
   output logic [DATA_W-1:0] ctrl_rd
);

   logic wr_hit;
   logic ovf_clr;
   logic en_q, frz_q, ovf_q;

   assign wr_hit  = bus_wr && (bus_addr == ADDR_W'(CTRL_OFS));
   assign cnt_clr = wr_hit && ctrl_wdata[CB_CLR];
   assign ovf_clr = cnt_clr && ctrl_wdata[CB_OVF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         frz_q <= 1'b0;
      end else if (wr_hit) begin
         en_q  <= ctrl_wdata[CB_EN];
         frz_q <= ctrl_wdata[CB_FRZ];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ovf_q <= 1'b0;
      else if (ovf_clr)  ovf_q <= 1'b0;
      else if (tot_wrap) ovf_q <= 1'b1;
   end

   assign count_en = en_q && !frz_q;

   always_comb begin
      ctrl_rd         = '0;
      ctrl_rd[CB_EN]  = en_q;
      ctrl_rd[CB_FRZ] = frz_q;
      ctrl_rd[CB_OVF] = ovf_q;
   end

   assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !ovf_clr) |=> ovf_q);

   assert_wrap_sets_ovf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tot_wrap && !ovf_clr) |=> ovf_q);

   assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (en_q == $past(ctrl_wdata[CB_EN]) && frz_q == $past(ctrl_wdata[CB_FRZ])));

endmodule

// File: rtl/prof_rdmux.sv
module prof_rdmux
   import prof_pkg::*;
#(
   parameter int ADDR_W   = 12,
   parameter int CNT_W    = 32,
   parameter int CTRL_OFS = 'h410,
   parameter int CNT_BASE = 'h418
) (
   input  logic [ADDR_W-1:0]             bus_addr,
   input  logic [DATA_W-1:0]             ctrl_rd,
   input  logic [NUM_CNT-1:0][CNT_W-1:0] cnt,
   output logic [DATA_W-1:0]             bus_rdata
);

   localparam int WORD_B = DATA_W / 8;

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CTRL_OFS)) bus_rdata = ctrl_rd;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (bus_addr == ADDR_W'(CNT_BASE + WORD_B * i)) bus_rdata = DATA_W'(cnt[i]);
      end
   end

endmodule

// File: rtl/mem_prof_counters.sv
module mem_prof_counters
   import prof_pkg::*;
#(
   parameter int CNT_W    = 32,
   parameter int BYTE_W   = 8,
   parameter int ADDR_W   = 12,
   parameter int CTRL_OFS = 'h410,
   parameter int CNT_BASE = 'h418
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ev_busy,
   input  logic              ev_rd_done,
   input  logic [BYTE_W-1:0] ev_rd_bytes,
   input  logic              ev_wr_done,
   input  logic [BYTE_W-1:0] ev_wr_bytes
);

   localparam int CNT_END = CNT_BASE + (DATA_W / 8) * NUM_CNT;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("mem_prof_counters: CNT_W must be in 2..32");
   end
   if (BYTE_W < 1 || BYTE_W > CNT_W) begin : g_bad_byte_w
      $error("mem_prof_counters: BYTE_W must be in 1..CNT_W");
   end
   if ((CTRL_OFS % 4) != 0 || (CNT_BASE % 4) != 0) begin : g_bad_align
      $error("mem_prof_counters: offsets must be word aligned");
   end
   if (CTRL_OFS >= CNT_BASE && CTRL_OFS < CNT_END) begin : g_bad_overlap
      $error("mem_prof_counters: control offset overlaps counters");
   end
   if (CNT_END > (1 << ADDR_W)) begin : g_bad_addr_w
      $error("mem_prof_counters: ADDR_W too narrow for the map");
   end

   logic                            count_en;
   logic                            cnt_clr;
   logic                            tot_wrap;
   logic [DATA_W-1:0]               ctrl_rd;
   logic [NUM_CNT-1:0][CNT_W-1:0]   cnt;
   logic [NUM_CNT-1:0]              inc_en;
   logic [NUM_CNT-1:0][BYTE_W-1:0]  inc_val;
   logic [DATA_W-1:0]               unused_wdata;

   assign unused_wdata = {bus_wdata[DATA_W-1:CB_W], {CB_W{1'b0}}};

   prof_ctrl #(
      .ADDR_W   (ADDR_W),
      .CTRL_OFS (CTRL_OFS)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .ctrl_wdata (bus_wdata[CB_W-1:0]),
      .tot_wrap   (tot_wrap),
      .count_en   (count_en),
      .cnt_clr    (cnt_clr),
      .ctrl_rd    (ctrl_rd)
   );

   // event routing per counter slot
   always_comb begin
      inc_en[CNT_TOTAL]   = count_en;
      inc_val[CNT_TOTAL]  = BYTE_W'(1);
      inc_en[CNT_BUSY]    = count_en && ev_busy;
      inc_val[CNT_BUSY]   = BYTE_W'(1);
      inc_en[CNT_RDACC]   = count_en && ev_rd_done;
      inc_val[CNT_RDACC]  = BYTE_W'(1);
      inc_en[CNT_WRACC]   = count_en && ev_wr_done;
      inc_val[CNT_WRACC]  = BYTE_W'(1);
      inc_en[CNT_RDBYTE]  = count_en && ev_rd_done;
      inc_val[CNT_RDBYTE] = ev_rd_bytes;
      inc_en[CNT_WRBYTE]  = count_en && ev_wr_done;
      inc_val[CNT_WRBYTE] = ev_wr_bytes;
   end

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      prof_counter #(
         .CNT_W (CNT_W),
         .INC_W (BYTE_W)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .clr     (cnt_clr),
         .inc_en  (inc_en[i]),
         .inc_val (inc_val[i]),
         .count   (cnt[i])
      );
   end

   assign tot_wrap = count_en && !cnt_clr && (cnt[CNT_TOTAL] == {CNT_W{1'b1}});

   prof_rdmux #(
      .ADDR_W   (ADDR_W),
      .CNT_W    (CNT_W),
      .CTRL_OFS (CTRL_OFS),
      .CNT_BASE (CNT_BASE)
   ) u_rdmux (
      .bus_addr  (bus_addr),
      .ctrl_rd   (ctrl_rd),
      .cnt       (cnt),
      .bus_rdata (bus_rdata)
   );

   assert_total_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (count_en && !cnt_clr) |=> (cnt[CNT_TOTAL] == CNT_W'($past(cnt[CNT_TOTAL]) + 1'b1)));

   assert_busy_le_total_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!count_en && !cnt_clr) |=> $stable(cnt));

endmodule

// File: tb/test_mem_prof_counters.sv
`timescale 1ns/1ps
module test_mem_prof_counters;

   localparam int CW   = 8;
   localparam int BW   = 4;
   localparam int AW   = 12;
   localparam int CTRL = 'h410;
   localparam int BASE = 'h418;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          ev_busy = 1'b0;
   logic          ev_rd_done = 1'b0;
   logic [BW-1:0] ev_rd_bytes = '0;
   logic          ev_wr_done = 1'b0;
   logic [BW-1:0] ev_wr_bytes = '0;

   int n_tests = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   mem_prof_counters #(
      .CNT_W (CW), .BYTE_W (BW), .ADDR_W (AW), .CTRL_OFS (CTRL), .CNT_BASE (BASE)
   ) i_mem_prof_counters (
      .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .ev_busy (ev_busy),
      .ev_rd_done (ev_rd_done), .ev_rd_bytes (ev_rd_bytes),
      .ev_wr_done (ev_wr_done), .ev_wr_bytes (ev_wr_bytes)
   );

   // arithmetic expectation, stepped from the requirements
   logic          m_en = 1'b0, m_frz = 1'b0, m_ovf = 1'b0;
   logic [CW-1:0] m_cnt [6];

   initial for (int i = 0; i < 6; i++) m_cnt[i] = '0;

   always @(posedge clk) begin
      logic hit, act;
      hit = bus_wr && (bus_addr == AW'(CTRL));
      act = m_en && !m_frz;
      if (!rst_n) begin
         m_en <= 1'b0; m_frz <= 1'b0; m_ovf <= 1'b0;
         for (int i = 0; i < 6; i++) m_cnt[i] <= '0;
      end else begin
         if (hit) begin
            m_en  <= bus_wdata[0];
            m_frz <= bus_wdata[2];
         end
         if (hit && bus_wdata[1]) begin                      // R3
            for (int i = 0; i < 6; i++) m_cnt[i] <= '0;
            if (bus_wdata[3]) m_ovf <= 1'b0;
         end else if (act) begin                             // R4
            m_cnt[0] <= m_cnt[0] + 1'b1;                     // R5, R10
            if (m_cnt[0] == '1) m_ovf <= 1'b1;               // R8
            if (ev_busy)    m_cnt[1] <= m_cnt[1] + 1'b1;
            if (ev_rd_done) m_cnt[2] <= m_cnt[2] + 1'b1;     // R6
            if (ev_wr_done) m_cnt[3] <= m_cnt[3] + 1'b1;
            if (ev_rd_done) m_cnt[4] <= m_cnt[4] + CW'(ev_rd_bytes);
            if (ev_wr_done) m_cnt[5] <= m_cnt[5] + CW'(ev_wr_bytes);
         end
      end
   end

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(logic wr, int addr, logic [31:0] wd, logic b, logic rd,
                        logic [BW-1:0] rb, logic w, logic [BW-1:0] wb);
      @(negedge clk);
      bus_wr = wr; bus_addr = AW'(addr); bus_wdata = wd;
      ev_busy = b; ev_rd_done = rd; ev_rd_bytes = rb; ev_wr_done = w; ev_wr_bytes = wb;
   endtask

   task automatic ctrl_wr(logic [31:0] v);
      drive(1'b1, CTRL, v, 1'b0, 1'b0, '0, 1'b0, '0);
   endtask

   // reads every mapped register in one low clock phase
   task automatic check_all(string tag);
      @(negedge clk);
      bus_wr = 1'b0; ev_busy = 1'b0; ev_rd_done = 1'b0; ev_wr_done = 1'b0;
      ev_rd_bytes = '1; ev_wr_bytes = '1;
      bus_addr = AW'(CTRL); #0.2;
      check({tag, " R2 ctrl"}, bus_rdata, {28'd0, m_ovf, m_frz, 1'b0, m_en});
      for (int i = 0; i < 6; i++) begin
         bus_addr = AW'(BASE + 4 * i); #0.2;
         check({tag, " R7 counter"}, bus_rdata, {24'd0, m_cnt[i]});
      end
   endtask

   task automatic events(int n, int seed);
      for (int k = 0; k < n; k++) begin
         int v;
         v = k * 37 + seed;
         drive(1'b0, 'h000, '0, v[0], v[1], v[5:2], v[6], v[10:7]);
      end
   endtask

   initial begin
      logic [CW-1:0] snap [6];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_all("R1 reset");

      // exhaustive sweep of event input combinations while counting
      ctrl_wr(32'h1);
      for (int k = 0; k < 2048; k++) begin
         drive(1'b0, 'h000, '0, k[0], k[1], k[5:2], k[6], k[10:7]);
         if (k % 256 == 255) check_all("R5 R6 R10 R8 sweep");
      end

      // freeze, stray events must not move counters
      ctrl_wr(32'h5);
      check_all("R2 freeze readback");
      for (int i = 0; i < 6; i++) snap[i] = m_cnt[i];
      events(40, 3);
      check_all("R4 frozen");
      for (int i = 0; i < 6; i++) begin
         bus_addr = AW'(BASE + 4 * i); #0.1;
         check("R11 held value", bus_rdata, {24'd0, snap[i]});
      end
      ctrl_wr(32'h1);
      events(25, 11);
      check_all("R11 resume");

      // disabled: nothing moves
      ctrl_wr(32'h0);
      events(30, 5);
      check_all("R4 disabled");

      // stray writes and unmapped reads
      drive(1'b1, BASE, 32'hFFFF_FFFF, 1'b0, 1'b0, '0, 1'b0, '0);
      drive(1'b1, BASE + 20, 32'hFFFF_FFFF, 1'b0, 1'b0, '0, 1'b0, '0);
      drive(1'b1, 'h414, 32'h0000_000F, 1'b0, 1'b0, '0, 1'b0, '0);
      check_all("R9 stray writes");
      foreach (snap[i]) ;
      begin
         int unm [5] = '{'h000, 'h414, 'h430, 'h40C, 'h41A};
         @(negedge clk);
         bus_wr = 1'b0;
         for (int i = 0; i < 5; i++) begin
            bus_addr = AW'(unm[i]); #0.2;
            check("R9 unmapped read", bus_rdata, 32'd0);
         end
      end

      // clear alone keeps the overflow flag, clear with bit 3 drops it
      check("R8 flag set before clear", {31'd0, m_ovf}, 32'd1);
      ctrl_wr(32'h2);
      check_all("R3 clear keeps flag");
      ctrl_wr(32'h3);
      events(300, 7);
      check_all("R8 R10 wrap again");
      ctrl_wr(32'hA);
      check_all("R3 clear drops flag");
      ctrl_wr(32'hB);
      events(10, 1);
      check_all("R3 clear with enable");

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(4 * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule